// File: doc/BRIEF.md
# Region-Based Address Protection and Translation Unit

This unit gives a processor without a paging MMU a coarse form of memory protection and relocation. The top bits of every virtual address pick one of eight equal regions of the 4 GB space. Each region holds a physical base and a 4-bit attribute code. The instruction side and the data side each keep their own copy of this table. An instruction fetch looks up the instruction table, and a load or store looks up the data table. The attribute decodes into read, write and execute permissions and a cache policy. An access that lacks the permission it needs returns a fault cause, and its physical address output is forced to zero.

A configuration write port sets the base and attribute of one region on one side per cycle. When the fallback mode input is high, the region tables are ignored. The address then passes through untranslated, and the attribute is the 4-bit nibble of a 32-bit cache-attribute word, chosen by the region index. Fallback mode decodes attributes with a slightly narrower table than region mode. Each lookup takes one cycle: a request sampled on one rising edge gives its result on the registered outputs after that edge.

Top module: `region_xlate_unit`

## Requirements
- R1: After reset, region i on both sides has physical base i and attribute 2, so every address maps to itself with read, write, execute and cache bypass. All response outputs are zero.
- R2: `rspValid` is high in the cycle after `reqValid` was sampled high, and low otherwise. The other response outputs change only when a request is taken.
- R3: The region index is virtual address bits 31:29. In region mode the physical address is the region base (3 bits) in bits 31:29, with virtual bits 28:0 below it.
- R4: Attribute decode uses perm {R,W,X} and cache code 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate. Code 0 gives RW- write-through, 1 gives RWX write-through, 2 gives RWX bypass, 3 gives --X write-back, 4 gives RWX write-back, 5 gives RWX write-back (region mode only), and 14 gives RW- isolate. Every other code gives no permission and cache code 0.
- R5: A fetch needs X, a store needs W and a load needs R. When the needed permission is missing, `rspCause` is 20 for a fetch, 29 for a store and 28 for a load. It is 0 on success.
- R6: When `rspCause` is nonzero, `rspPaddr` is zero. The permission and cache outputs still show the decoded attribute.
- R7: A fetch uses the instruction table and a load or store uses the data table. `cfgSideData` (0 instruction, 1 data) selects the table a configuration write changes. A write to one side leaves the other side unchanged.
- R8: In fallback mode the physical address equals the virtual address. The attribute is bits [4*i+3:4*i] of `fallbackAttrs`, where i is the region index. Region table contents have no effect.
- R9: In fallback mode, attribute code 5 gives no permission and cache code 0.
- R10: A lookup in the same cycle as a configuration write to its entry sees the old entry. The next cycle sees the new one.
- R11: When `reqFetch` is high the access counts as a fetch, whatever the value of `reqWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSideData | input | 1 | Table to write: 0 instruction, 1 data |
| cfgIdx | input | 3 | Region to write |
| cfgBase | input | 3 | New physical base (address bits 31:29) |
| cfgAttr | input | 4 | New attribute code |
| modeFallback | input | 1 | 1 selects fallback mode |
| fallbackAttrs | input | 32 | Cache-attribute word, one nibble per region |
| reqValid | input | 1 | Lookup request |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqWrite | input | 1 | Data request is a store (otherwise a load) |
| reqAddr | input | 32 | Virtual address |
| rspValid | output | 1 | Result valid |
| rspPaddr | output | 32 | Physical address, zero on fault |
| rspRead | output | 1 | Decoded read permission |
| rspWrite | output | 1 | Decoded write permission |
| rspExec | output | 1 | Decoded execute permission |
| rspCache | output | 3 | Decoded cache code |
| rspCause | output | 6 | Fault cause, 0 on success |

## Verification
The bench sets the two sides to different contents for the same region. A design that mixes up the tables would then give the wrong base or a false fault on a fetch. It checks attribute 5 in both modes, where a shared decoder would wrongly grant access in fallback mode. It checks a fetch with the write bit set, which a design that gives the write bit priority would fault as a store. It also writes an entry and looks it up in the same cycle, followed by a lookup in the next cycle. A design that bypasses the new entry into the lookup, or one that delays the update, would give the wrong result in one of these two cycles. Faulting accesses are checked for a zero address and the cause that matches their type. Fallback lookups use regions whose table base has been changed, so any leak of the translation shows up in the address.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [2:0] {
    CM_NONE    = 3'd0,
    CM_BYPASS  = 3'd1,
    CM_WTHRU   = 3'd2,
    CM_WBACK   = 3'd3,
    CM_ISOLATE = 3'd4
  } cacheMode_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    cacheMode_e cache;
  } accessInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrInstr;
    logic wrData;
    logic capture;
    logic useData;
    logic fallback;
    logic wantExec;
    logic wantWrite;
  } ctlStrobe_t;

  localparam int CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_OK    = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 6'd20;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 6'd28;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 6'd29;

  // fallbackTbl narrows the decode: code 5 is only defined in region mode
  function automatic accessInfo_t decodeAttr(input logic [3:0] code,
                                             input logic fallbackTbl);
    accessInfo_t r;
    r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cache: CM_NONE};
    unique case (code)
      4'd0:  r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cache: CM_WTHRU};
      4'd1:  r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cache: CM_WTHRU};
      4'd2:  r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cache: CM_BYPASS};
      4'd3:  r = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, cache: CM_WBACK};
      4'd4:  r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cache: CM_WBACK};
      4'd5:  if (!fallbackTbl)
               r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cache: CM_WBACK};
      4'd14: r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cache: CM_ISOLATE};
      default: r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cache: CM_NONE};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rpt_region_table.sv
module rpt_region_table #(
  parameter int REGION_BITS = 3,
  parameter int ATTR_W      = 4,
  parameter int RESET_ATTR  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [REGION_BITS-1:0] wrIdx,
  input  logic [REGION_BITS-1:0] wrBase,
  input  logic [ATTR_W-1:0]      wrAttr,
  input  logic [REGION_BITS-1:0] rdIdx,
  output logic [REGION_BITS-1:0] rdBase,
  output logic [ATTR_W-1:0]      rdAttr
);
  localparam int NUM_REGIONS = 1 << REGION_BITS;

  logic [REGION_BITS-1:0] baseQ [NUM_REGIONS];
  logic [ATTR_W-1:0]      attrQ [NUM_REGIONS];

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[gi] <= REGION_BITS'(gi);
        attrQ[gi] <= ATTR_W'(RESET_ATTR);
      end else if (wrEn && (wrIdx == REGION_BITS'(gi))) begin
        baseQ[gi] <= wrBase;
        attrQ[gi] <= wrAttr;
      end
    end
  end

  assign rdBase = baseQ[rdIdx];
  assign rdAttr = attrQ[rdIdx];
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgSideData,
  input  logic       modeFallback,
  input  logic       reqValid,
  input  logic       reqFetch,
  input  logic       reqWrite,
  output ctlStrobe_t strobe,
  output logic       rspValid
);
  always_comb begin
    strobe.wrInstr   = cfgWrEn && !cfgSideData;
    strobe.wrData    = cfgWrEn && cfgSideData;
    strobe.capture   = reqValid;
    strobe.useData   = !reqFetch;
    strobe.fallback  = modeFallback;
    strobe.wantExec  = reqFetch;
    strobe.wantWrite = !reqFetch && reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 3,
  parameter int ATTR_W      = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ctlStrobe_t                           strobe,
  input  logic [REGION_BITS-1:0]               cfgIdx,
  input  logic [REGION_BITS-1:0]               cfgBase,
  input  logic [ATTR_W-1:0]                    cfgAttr,
  input  logic [(ATTR_W<<REGION_BITS)-1:0]     fallbackAttrs,
  input  logic [ADDR_W-1:0]                    reqAddr,
  output logic [ADDR_W-1:0]                    rspPaddr,
  output logic                                 rspRead,
  output logic                                 rspWrite,
  output logic                                 rspExec,
  output logic [2:0]                           rspCache,
  output logic [CAUSE_W-1:0]                   rspCause
);
  localparam int OFFS_W = ADDR_W - REGION_BITS;
  localparam int NSIDES = 2;

  logic [REGION_BITS-1:0] regionIdx;
  logic [REGION_BITS-1:0] sideBase [NSIDES];
  logic [ATTR_W-1:0]      sideAttr [NSIDES];
  logic [REGION_BITS-1:0] selBase;
  logic [ATTR_W-1:0]      selAttr;
  logic [ATTR_W-1:0]      fbAttr;
  logic [ATTR_W-1:0]      useAttr;
  accessInfo_t            info;
  logic [ADDR_W-1:0]      xlated;
  logic                   granted;
  logic [CAUSE_W-1:0]     causeNext;

  assign regionIdx = reqAddr[ADDR_W-1 -: REGION_BITS];

  // side 0 = instruction, side 1 = data
  for (genvar gs = 0; gs < NSIDES; gs++) begin : gSide
    logic sideWr;
    assign sideWr = (gs == 0) ? strobe.wrInstr : strobe.wrData;
    rpt_region_table #(
      .REGION_BITS(REGION_BITS),
      .ATTR_W     (ATTR_W),
      .RESET_ATTR (2)
    ) uTable (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (sideWr),
      .wrIdx (cfgIdx),
      .wrBase(cfgBase),
      .wrAttr(cfgAttr),
      .rdIdx (regionIdx),
      .rdBase(sideBase[gs]),
      .rdAttr(sideAttr[gs])
    );
  end

  always_comb begin
    selBase = strobe.useData ? sideBase[1] : sideBase[0];
    selAttr = strobe.useData ? sideAttr[1] : sideAttr[0];
    fbAttr  = fallbackAttrs[regionIdx*ATTR_W +: ATTR_W];
    useAttr = strobe.fallback ? fbAttr : selAttr;
    info    = decodeAttr(useAttr, strobe.fallback);
    xlated  = strobe.fallback ? reqAddr : {selBase, reqAddr[OFFS_W-1:0]};
    if (strobe.wantExec)       granted = info.ex;
    else if (strobe.wantWrite) granted = info.wr;
    else                       granted = info.rd;
    if (granted)               causeNext = CAUSE_OK;
    else if (strobe.wantExec)  causeNext = CAUSE_FETCH;
    else if (strobe.wantWrite) causeNext = CAUSE_STORE;
    else                       causeNext = CAUSE_LOAD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
      rspCache <= '0;
      rspCause <= '0;
    end else if (strobe.capture) begin
      rspPaddr <= granted ? xlated : '0;
      rspRead  <= info.rd;
      rspWrite <= info.wr;
      rspExec  <= info.ex;
      rspCache <= info.cache;
      rspCause <= causeNext;
    end
  end
endmodule

// File: rtl/region_xlate_unit.sv
module region_xlate_unit
  import rpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 3,
  parameter int ATTR_W      = 4,
  localparam int FB_W       = ATTR_W << REGION_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgSideData,
  input  logic [REGION_BITS-1:0] cfgIdx,
  input  logic [REGION_BITS-1:0] cfgBase,
  input  logic [ATTR_W-1:0]      cfgAttr,
  input  logic                   modeFallback,
  input  logic [FB_W-1:0]        fallbackAttrs,
  input  logic                   reqValid,
  input  logic                   reqFetch,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   rspValid,
  output logic [ADDR_W-1:0]      rspPaddr,
  output logic                   rspRead,
  output logic                   rspWrite,
  output logic                   rspExec,
  output logic [2:0]             rspCache,
  output logic [CAUSE_W-1:0]     rspCause
);
  ctlStrobe_t strobe;

  rpt_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgSideData (cfgSideData),
    .modeFallback(modeFallback),
    .reqValid    (reqValid),
    .reqFetch    (reqFetch),
    .reqWrite    (reqWrite),
    .strobe      (strobe),
    .rspValid    (rspValid)
  );

  rpt_datapath #(
    .ADDR_W     (ADDR_W),
    .REGION_BITS(REGION_BITS),
    .ATTR_W     (ATTR_W)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgIdx       (cfgIdx),
    .cfgBase      (cfgBase),
    .cfgAttr      (cfgAttr),
    .fallbackAttrs(fallbackAttrs),
    .reqAddr      (reqAddr),
    .rspPaddr     (rspPaddr),
    .rspRead      (rspRead),
    .rspWrite     (rspWrite),
    .rspExec      (rspExec),
    .rspCache     (rspCache),
    .rspCause     (rspCause)
  );
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqFetch,
  input logic              reqWrite,
  input logic              modeFallback,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspRead,
  input logic              rspWrite,
  input logic              rspExec,
  input logic [2:0]        rspCache,
  input logic [5:0]        rspCause
);
  localparam int OFFS_W = ADDR_W - REGION_BITS;

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCause != 6'd0) |-> rspPaddr == '0);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !modeFallback) |=>
      (rspCause != 6'd0 || rspPaddr[OFFS_W-1:0] == $past(reqAddr[OFFS_W-1:0])));

  assert_fallback_identity_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeFallback) |=> (rspCause != 6'd0 || rspPaddr == $past(reqAddr)));

  assert_fetch_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFetch) |=> (rspExec ? rspCause == 6'd0 : rspCause == 6'd20));

  assert_store_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFetch && reqWrite) |=> (rspWrite ? rspCause == 6'd0 : rspCause == 6'd29));

  assert_load_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFetch && !reqWrite) |=> (rspRead ? rspCause == 6'd0 : rspCause == 6'd28));

  assert_isolate_no_exec_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCache == 3'd4) |-> (!rspExec && rspRead && rspWrite));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(rspPaddr) && $stable(rspCause));
endmodule

bind region_xlate_unit rpt_checker #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqFetch    (reqFetch),
  .reqWrite    (reqWrite),
  .modeFallback(modeFallback),
  .reqAddr     (reqAddr),
  .rspValid    (rspValid),
  .rspPaddr    (rspPaddr),
  .rspRead     (rspRead),
  .rspWrite    (rspWrite),
  .rspExec     (rspExec),
  .rspCache    (rspCache),
  .rspCause    (rspCause)
);

// File: tb/tb_region_xlate_unit.sv
module tb_region_xlate_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSideData = 1'b0;
  logic [2:0]  cfgIdx = '0, cfgBase = '0;
  logic [3:0]  cfgAttr = '0;
  logic        modeFallback = 1'b0;
  logic [31:0] fallbackAttrs = 32'h0E05_4321;
  logic        reqValid = 1'b0, reqFetch = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspRead, rspWrite, rspExec;
  logic [31:0] rspPaddr;
  logic [2:0]  rspCache;
  logic [5:0]  rspCause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  region_xlate_unit dut (.*);

  // {fb, fetch, write, addr, expPaddr, perm RWX, cache, cause}
  localparam int NV = 18;
  localparam logic [78:0] VEC [NV] = '{
    {3'b000, 32'h2000_1234, 32'hA000_1234, 3'b110, 3'd2, 6'd0 },  // R7 data r1
    {3'b001, 32'h2000_1234, 32'hA000_1234, 3'b110, 3'd2, 6'd0 },  // R3
    {3'b010, 32'h2000_0010, 32'hC000_0010, 3'b001, 3'd3, 6'd0 },  // R7 instr r1
    {3'b001, 32'h4000_0008, 32'h0000_0000, 3'b001, 3'd3, 6'd29},  // R5 R6
    {3'b000, 32'h4ABC_0000, 32'h0000_0000, 3'b001, 3'd3, 6'd28},  // R5
    {3'b010, 32'h0000_0100, 32'h0000_0000, 3'b110, 3'd2, 6'd20},  // R5 R4
    {3'b011, 32'h4000_0004, 32'h4000_0004, 3'b111, 3'd1, 6'd0 },  // R11
    {3'b000, 32'h7FFF_FFFC, 32'h7FFF_FFFC, 3'b110, 3'd4, 6'd0 },  // R4 iso
    {3'b001, 32'h9000_0000, 32'h0000_0000, 3'b000, 3'd0, 6'd29},  // R4 undef
    {3'b000, 32'hA000_0040, 32'hA000_0040, 3'b111, 3'd3, 6'd0 },  // R4 code5
    {3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111, 3'd1, 6'd0 },  // R3
    {3'b100, 32'h2000_1234, 32'h2000_1234, 3'b111, 3'd1, 6'd0 },  // R8
    {3'b101, 32'h4000_0000, 32'h0000_0000, 3'b001, 3'd3, 6'd29},  // R8
    {3'b110, 32'h8000_0000, 32'h0000_0000, 3'b000, 3'd0, 6'd20},  // R9
    {3'b100, 32'hC000_0000, 32'hC000_0000, 3'b110, 3'd4, 6'd0 },  // R8
    {3'b110, 32'h0000_0000, 32'h0000_0000, 3'b111, 3'd2, 6'd0 },  // R8
    {3'b101, 32'h6000_0000, 32'h6000_0000, 3'b111, 3'd3, 6'd0 },  // R8
    {3'b100, 32'hA000_0000, 32'hA000_0000, 3'b110, 3'd2, 6'd0 }   // R8
  };

  task automatic checkRsp(input string tag, input logic [31:0] ePa,
                          input logic [2:0] ePerm, input logic [2:0] eCache,
                          input logic [5:0] eCause);
    total++;
    if (!rspValid || rspPaddr !== ePa || {rspRead, rspWrite, rspExec} !== ePerm ||
        rspCache !== eCache || rspCause !== eCause) begin
      bad++;
      $display("FAIL %s: got v=%0b pa=%h perm=%b c=%0d cause=%0d exp pa=%h perm=%b c=%0d cause=%0d",
               tag, rspValid, rspPaddr, {rspRead, rspWrite, rspExec}, rspCache, rspCause,
               ePa, ePerm, eCache, eCause);
    end
  endtask

  task automatic cfgWrite(input logic side, input logic [2:0] idx,
                          input logic [2:0] base, input logic [3:0] attr);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSideData = side; cfgIdx = idx; cfgBase = base; cfgAttr = attr;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic lookup(input logic fb, input logic f, input logic w, input logic [31:0] a);
    @(negedge clk);
    modeFallback = fb; reqFetch = f; reqWrite = w; reqAddr = a; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset outputs
    total++;
    if (rspValid !== 1'b0 || rspPaddr !== '0 || rspCause !== '0 || rspCache !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs: got v=%0b pa=%h cause=%0d expected zeros", rspValid, rspPaddr, rspCause);
    end
    rstN = 1'b1;

    // R1: identity with attribute 2 on both sides
    lookup(1'b0, 1'b0, 1'b0, 32'hE000_0001);
    checkRsp("R1 data identity", 32'hE000_0001, 3'b111, 3'd1, 6'd0);
    lookup(1'b0, 1'b1, 1'b0, 32'h2345_6789);
    checkRsp("R1 instr identity", 32'h2345_6789, 3'b111, 3'd1, 6'd0);

    // R2: idle cycle drops valid, holds data
    @(negedge clk);
    total++;
    if (rspValid !== 1'b0 || rspPaddr !== 32'h2345_6789) begin
      bad++;
      $display("FAIL R2 idle: got v=%0b pa=%h expected v=0 pa=23456789", rspValid, rspPaddr);
    end

    // configure tables
    cfgWrite(1'b1, 3'd1, 3'd5, 4'd0);
    cfgWrite(1'b1, 3'd2, 3'd2, 4'd3);
    cfgWrite(1'b1, 3'd3, 3'd3, 4'd14);
    cfgWrite(1'b1, 3'd4, 3'd4, 4'd9);
    cfgWrite(1'b1, 3'd5, 3'd5, 4'd5);
    cfgWrite(1'b0, 3'd1, 3'd6, 4'd3);
    cfgWrite(1'b0, 3'd0, 3'd0, 4'd0);
    cfgWrite(1'b0, 3'd4, 3'd1, 4'd5);  // instr r4: fallback must ignore it

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][78], VEC[i][77], VEC[i][76], VEC[i][75:44]);
      checkRsp($sformatf("vector %0d", i), VEC[i][43:12], VEC[i][11:9], VEC[i][8:6], VEC[i][5:0]);
    end

    // R10: write data r6 to attr 3 while storing to it in the same cycle
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSideData = 1'b1; cfgIdx = 3'd6; cfgBase = 3'd0; cfgAttr = 4'd3;
    modeFallback = 1'b0; reqFetch = 1'b0; reqWrite = 1'b1; reqAddr = 32'hC000_0010; reqValid = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    checkRsp("R10 old entry", 32'hC000_0010, 3'b111, 3'd1, 6'd0);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R10 new entry", 32'h0000_0000, 3'b001, 3'd3, 6'd29);

    // R7: instruction r6 untouched by data write
    lookup(1'b0, 1'b1, 1'b0, 32'hC000_0000);
    checkRsp("R7 instr r6 untouched", 32'hC000_0000, 3'b111, 3'd1, 6'd0);

    // R6 + R3: data fetch of r6 relocated base 0 via load (attr 3 denies load)
    lookup(1'b0, 1'b0, 1'b0, 32'hC000_0010);
    checkRsp("R6 load denied", 32'h0000_0000, 3'b001, 3'd3, 6'd28);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule